// File: doc/BRIEF.md
# Strap-Configured MDIO PHY Emulation Slave

This block is the management side of a device that presents itself to an external Ethernet MAC as if it were a 10/100 PHY. The MII datapath is reversed: the device plays the PHY. On the first clock after reset is released, the block samples five configuration pins. Three of them set the default link speed, the default duplex and whether the device starts isolated. The other two choose one of four management addresses, spaced eight apart. The block then answers clause-22 MDIO read and write frames, but only those sent to that address.

The block holds a control register and a status register. The control register's power-up value comes from the sampled pins. The status register always reports that auto-negotiation is not available. It also provides two identifier registers. The control register drives the speed, duplex and isolate levels used by the MII datapath, together with an output-enable that the datapath uses to tri-state its receive-side outputs. The receive error output is not covered by this enable.

Local firmware can rewrite the control register at any time through a one-cycle write strobe. The firmware write follows the same rules as an MDIO write.

Top module: `mdio_phy_emu`

## Requirements
- R1: On the first clock edge after rst_ni goes high, the block captures the pins into the control register: speed pin into bit 13 (1 = 100 Mbps), isolate pin into bit 10 (1 = isolated), duplex pin into bit 8 (1 = full). All other bits are 0. While in reset, and until that edge, isolate_o is 1.
- R2: The management address is {addr_pins_i, 3'b000}: pin values 00, 01, 10 and 11 give addresses 0x00, 0x08, 0x10 and 0x18.
- R3: A frame is sampled on rising MDC edges, MSB first, in this order: at least PRE_MIN (32) ones, then start bits 0 1, a 2-bit opcode (10 = read, 01 = write), a 5-bit PHY address, a 5-bit register address and a 2-bit turnaround. On a read, the slave leaves MDIO released for the first turnaround bit and drives 0 for the second. It then drives 16 data bits, MSB first, and releases the line after the last bit. A frame with a shorter preamble gets no response.
- R4: A frame sent to any other PHY address changes no register, and mdio_oe_o stays 0 for the whole frame.
- R5: Register 1 (status) always reads 0x7805. Bit 3 (auto-negotiation ability) and bit 5 (auto-negotiation complete) are 0, and writes to this register have no effect.
- R6: In register 0, only bits 14, 13, 10 and 8 can be written. All other bits read 0, including bit 12 (auto-negotiation enable).
- R7: A write to register 0 with bit 15 set reloads the values captured from the pins and ignores the other data bits. Bit 15 then reads 0.
- R8: A firmware write (fw_we_i high for one cycle) updates register 0 under the same rules as R6 and R7. If it coincides with an MDIO write, the firmware write takes priority.
- R9: speed_100_o, full_duplex_o and isolate_o follow bits 13, 8 and 10 of register 0 from the clock edge after a write. mii_out_en_o is the inverse of isolate_o.
- R10: Registers 2 and 3 read the PHY_ID_HI and PHY_ID_LO parameters (defaults 0x2A5C and 0x9C31). Registers 4 to 31 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_speed_i | input | 1 | Speed pin, 1 = 100 Mbps |
| strap_duplex_i | input | 1 | Duplex pin, 1 = full duplex |
| strap_iso_i | input | 1 | Isolate pin, 1 = start isolated |
| strap_addr_i | input | 2 | Management address select pins |
| mdc_i | input | 1 | Management clock from the MAC, oversampled |
| mdio_i | input | 1 | Management data in |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| fw_we_i | input | 1 | Firmware write strobe for register 0 |
| fw_wdata_i | input | 16 | Firmware write data |
| speed_100_o | output | 1 | Current speed, 1 = 100 Mbps |
| full_duplex_o | output | 1 | Current duplex, 1 = full |
| isolate_o | output | 1 | Current isolate state |
| mii_out_en_o | output | 1 | Enable for the tri-stated MII receive-side outputs |

## Verification
The bench uses two pin settings, addresses 0x08 and 0x18, to tell apart a correct pin capture from a fixed default. Reads of every register kind separate the constant status register, the parameterised identifiers and unmapped locations. Writes with masked-off bits set, writes to the read-only status register, writes to the wrong address and writes with a short preamble each test one way in which a frame must leave the control register unchanged. Turnaround and release timing are sampled at the bit positions where the external MAC would sample them. Firmware writes, including a reset-bit write, are then checked both at the outputs and by MDIO readback.

// File: rtl/mdio_emu_pkg.sv
package mdio_emu_pkg;
  localparam logic [1:0]  OP_WR = 2'b01;
  localparam logic [1:0]  OP_RD = 2'b10;
  localparam logic [4:0]  REG_CTRL = 5'd0;
  localparam logic [4:0]  REG_STAT = 5'd1;
  localparam logic [4:0]  REG_ID1  = 5'd2;
  localparam logic [4:0]  REG_ID2  = 5'd3;
  localparam logic [15:0] CTRL_WMASK = 16'h6500;
  localparam logic [15:0] STAT_VAL   = 16'h7805;
  localparam logic [15:0] CTRL_RST_VAL = 16'h0400;
  localparam int CB_RST = 15;
  localparam int CB_SPD = 13;
  localparam int CB_ISO = 10;
  localparam int CB_DUP = 8;

  typedef struct packed {
    logic       speed;
    logic       duplex;
    logic       iso;
    logic [1:0] addr;
  } strap_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ST, S_HDR, S_RTA1, S_RTA2, S_RDAT, S_WTA, S_WDAT
  } frame_st_e;

  function automatic logic [15:0] ctrl_dflt(strap_t s);
    ctrl_dflt = '0;
    ctrl_dflt[CB_SPD] = s.speed;
    ctrl_dflt[CB_ISO] = s.iso;
    ctrl_dflt[CB_DUP] = s.duplex;
  endfunction
endpackage

// File: rtl/mdio_emu_sync.sv
module mdio_emu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic bit_stb_o,
  output logic bit_o
);
  logic [STAGES-1:0] mdc_s, mdio_s;
  logic              mdc_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          mdc_s[0]  <= 1'b0;
          mdio_s[0] <= 1'b1;
        end else begin
          mdc_s[0]  <= mdc_i;
          mdio_s[0] <= mdio_i;
        end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          mdc_s[g]  <= 1'b0;
          mdio_s[g] <= 1'b1;
        end else begin
          mdc_s[g]  <= mdc_s[g-1];
          mdio_s[g] <= mdio_s[g-1];
        end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) mdc_d <= 1'b0;
    else         mdc_d <= mdc_s[STAGES-1];

  assign bit_stb_o = mdc_s[STAGES-1] & ~mdc_d;
  assign bit_o     = mdio_s[STAGES-1];
endmodule

// File: rtl/mdio_emu_frame.sv
module mdio_emu_frame
  import mdio_emu_pkg::*;
#(
  parameter int PRE_MIN = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bit_stb_i,
  input  logic        bit_i,
  input  logic [4:0]  my_addr_i,
  input  logic [15:0] rdata_i,
  output logic [4:0]  reg_addr_o,
  output logic        wr_stb_o,
  output logic [15:0] wdata_o,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  localparam int OW = $clog2(PRE_MIN + 1);

  frame_st_e   st_q;
  logic [OW-1:0] ones_q;
  logic [3:0]  cnt_q;
  logic [11:0] hdr_q;
  logic [15:0] sh_q;
  logic [4:0]  reg_q;
  logic        wr_q;
  logic [11:0] hdr_nx;

  assign hdr_nx = {hdr_q[10:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      ones_q <= '0;
      cnt_q  <= '0;
      hdr_q  <= '0;
      sh_q   <= '0;
      reg_q  <= '0;
      wr_q   <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (bit_stb_i) begin
        unique case (st_q)
          S_IDLE: begin
            if (bit_i) begin
              if (ones_q != OW'(PRE_MIN)) ones_q <= ones_q + 1'b1;
            end else begin
              if (ones_q == OW'(PRE_MIN)) st_q <= S_ST;
              ones_q <= '0;
            end
          end
          S_ST: begin
            cnt_q <= '0;
            st_q  <= bit_i ? S_HDR : S_IDLE;
          end
          S_HDR: begin
            hdr_q <= hdr_nx;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == 4'd11) begin
              reg_q <= hdr_nx[4:0];
              cnt_q <= '0;
              if (hdr_nx[9:5] != my_addr_i) st_q <= S_IDLE;
              else if (hdr_nx[11:10] == OP_RD) st_q <= S_RTA1;
              else if (hdr_nx[11:10] == OP_WR) st_q <= S_WTA;
              else st_q <= S_IDLE;
            end
          end
          S_RTA1: begin
            sh_q <= rdata_i;
            st_q <= S_RTA2;
          end
          S_RTA2: begin
            cnt_q <= '0;
            st_q  <= S_RDAT;
          end
          S_RDAT: begin
            sh_q  <= {sh_q[14:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == 4'd15) st_q <= S_IDLE;
          end
          S_WTA: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == 4'd1) begin
              cnt_q <= '0;
              st_q  <= S_WDAT;
            end
          end
          S_WDAT: begin
            sh_q  <= {sh_q[14:0], bit_i};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == 4'd15) begin
              wr_q <= 1'b1;
              st_q <= S_IDLE;
            end
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  assign reg_addr_o = reg_q;
  assign wr_stb_o   = wr_q;
  assign wdata_o    = sh_q;
  assign mdio_oe_o  = (st_q == S_RTA2) || (st_q == S_RDAT);
  assign mdio_o     = (st_q == S_RDAT) ? sh_q[15] : 1'b0;

  // R3
  ta_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdio_oe_o) |-> !mdio_o);
  // R3
  no_drive_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> !mdio_oe_o);
endmodule

// File: rtl/mdio_emu_regs.sv
module mdio_emu_regs
  import mdio_emu_pkg::*;
#(
  parameter logic [15:0] PHY_ID_HI = 16'h2A5C,
  parameter logic [15:0] PHY_ID_LO = 16'h9C31
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  strap_t      strap_i,
  input  logic [4:0]  addr_i,
  input  logic        wr_stb_i,
  input  logic [15:0] wdata_i,
  input  logic        fw_we_i,
  input  logic [15:0] fw_wdata_i,
  output logic [15:0] rdata_o,
  output logic [4:0]  my_addr_o,
  output logic [15:0] ctrl_o
);
  strap_t      strap_q;
  logic        init_q;
  logic [15:0] ctrl_q;
  logic [15:0] dflt;

  assign dflt = ctrl_dflt(strap_q);

  function automatic logic [15:0] apply(logic [15:0] w, logic [15:0] d);
    apply = w[CB_RST] ? d : (w & CTRL_WMASK);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q <= '0;
      init_q  <= 1'b0;
      ctrl_q  <= CTRL_RST_VAL;
    end else if (!init_q) begin
      strap_q <= strap_i;
      init_q  <= 1'b1;
      ctrl_q  <= ctrl_dflt(strap_i);
    end else if (fw_we_i) begin
      ctrl_q <= apply(fw_wdata_i, dflt);
    end else if (wr_stb_i && addr_i == REG_CTRL) begin
      ctrl_q <= apply(wdata_i, dflt);
    end
  end

  always_comb begin
    unique case (addr_i)
      REG_CTRL: rdata_o = ctrl_q;
      REG_STAT: rdata_o = STAT_VAL;
      REG_ID1:  rdata_o = PHY_ID_HI;
      REG_ID2:  rdata_o = PHY_ID_LO;
      default:  rdata_o = '0;
    endcase
  end

  assign my_addr_o = {strap_q.addr, 3'b000};
  assign ctrl_o    = ctrl_q;

  // R1
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q |=> $stable(strap_q));
  // R7
  fw_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && fw_we_i && fw_wdata_i[CB_RST]) |=> (ctrl_q == dflt) && !ctrl_q[CB_RST]);
  // R8
  fw_iso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && fw_we_i && !fw_wdata_i[CB_RST]) |=> ctrl_q[CB_ISO] == $past(fw_wdata_i[CB_ISO]));
endmodule

// File: rtl/mdio_phy_emu.sv
module mdio_phy_emu
  import mdio_emu_pkg::*;
#(
  parameter int          PRE_MIN     = 32,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] PHY_ID_HI   = 16'h2A5C,
  parameter logic [15:0] PHY_ID_LO   = 16'h9C31
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        strap_speed_i,
  input  logic        strap_duplex_i,
  input  logic        strap_iso_i,
  input  logic [1:0]  strap_addr_i,
  input  logic        mdc_i,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        fw_we_i,
  input  logic [15:0] fw_wdata_i,
  output logic        speed_100_o,
  output logic        full_duplex_o,
  output logic        isolate_o,
  output logic        mii_out_en_o
);
  logic        bit_stb, bit_v, wr_stb;
  logic [4:0]  reg_addr, my_addr;
  logic [15:0] rdata, wdata, ctrl;
  strap_t      straps;

  assign straps = '{speed: strap_speed_i, duplex: strap_duplex_i,
                    iso: strap_iso_i, addr: strap_addr_i};

  mdio_emu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .mdc_i, .mdio_i,
    .bit_stb_o(bit_stb), .bit_o(bit_v)
  );

  mdio_emu_frame #(.PRE_MIN(PRE_MIN)) u_frame (
    .clk_i, .rst_ni, .bit_stb_i(bit_stb), .bit_i(bit_v),
    .my_addr_i(my_addr), .rdata_i(rdata), .reg_addr_o(reg_addr),
    .wr_stb_o(wr_stb), .wdata_o(wdata), .mdio_o, .mdio_oe_o
  );

  mdio_emu_regs #(.PHY_ID_HI(PHY_ID_HI), .PHY_ID_LO(PHY_ID_LO)) u_regs (
    .clk_i, .rst_ni, .strap_i(straps), .addr_i(reg_addr),
    .wr_stb_i(wr_stb), .wdata_i(wdata), .fw_we_i, .fw_wdata_i,
    .rdata_o(rdata), .my_addr_o(my_addr), .ctrl_o(ctrl)
  );

  assign speed_100_o   = ctrl[CB_SPD];
  assign full_duplex_o = ctrl[CB_DUP];
  assign isolate_o     = ctrl[CB_ISO];
  assign mii_out_en_o  = ~ctrl[CB_ISO];

  // R6
  an_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb |=> !ctrl[12] && !ctrl[CB_RST]);
endmodule

// File: tb/mdio_phy_emu_bench.sv
module mdio_phy_emu_bench;
  localparam int HP = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic spd = 1, dup = 1, iso = 0;
  logic [1:0] adr = 2'b01;
  logic mdc = 0, mdio_drv = 1;
  logic mdio_o, mdio_oe;
  logic fw_we = 0;
  logic [15:0] fw_wd = '0;
  logic speed_o, dup_o, iso_o, men_o;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] exp_q[$], obs_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  mdio_phy_emu u_mdio_phy_emu (
    .clk_i(clk), .rst_ni(rst_n), .strap_speed_i(spd), .strap_duplex_i(dup),
    .strap_iso_i(iso), .strap_addr_i(adr), .mdc_i(mdc), .mdio_i(mdio_drv),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .fw_we_i(fw_we), .fw_wdata_i(fw_wd),
    .speed_100_o(speed_o), .full_duplex_o(dup_o), .isolate_o(iso_o),
    .mii_out_en_o(men_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (obs_q.size() > 0)
      check(tag_q.pop_front(), 32'(obs_q.pop_front()), 32'(exp_q.pop_front()));
  end

  task automatic xbit(input logic b, output logic s, output logic oe);
    mdio_drv = b;
    repeat (HP) @(negedge clk);
    oe = mdio_oe;
    s  = mdio_oe ? mdio_o : 1'b1;
    mdc = 1'b1;
    repeat (HP) @(negedge clk);
    mdc = 1'b0;
  endtask

  task automatic hdr(int npre, logic [1:0] op, logic [4:0] pa, logic [4:0] ra, inout bit any);
    logic s, oe;
    logic [13:0] h;
    h = {2'b01, op, pa, ra};
    for (int i = 0; i < npre; i++) begin xbit(1'b1, s, oe); any |= oe; end
    for (int i = 13; i >= 0; i--) begin xbit(h[i], s, oe); any |= oe; end
  endtask

  task automatic mrd(logic [4:0] pa, logic [4:0] ra, logic [15:0] exp, string req,
                     bit resp, int npre = 32);
    logic s, oe;
    logic [15:0] v;
    bit any = 0;
    hdr(npre, 2'b10, pa, ra, any);
    xbit(1'b1, s, oe);
    any |= oe;
    if (resp) check({req, " R3 ta1 released"}, 32'(oe), 0);
    xbit(1'b1, s, oe);
    any |= oe;
    if (resp) check({req, " R3 ta2 drive0"}, {30'd0, oe, s}, 32'b10);
    for (int i = 15; i >= 0; i--) begin xbit(1'b1, s, oe); v[i] = s; any |= oe; end
    repeat (4) @(negedge clk);
    if (resp) begin
      exp_q.push_back(exp); tag_q.push_back(req); obs_q.push_back(v);
      check({req, " R3 release"}, 32'(mdio_oe), 0);
    end else begin
      check({req, " no drive"}, 32'(any | mdio_oe), 0);
    end
  endtask

  task automatic mwr(logic [4:0] pa, logic [4:0] ra, logic [15:0] d, int npre = 32);
    logic s, oe;
    bit any = 0;
    hdr(npre, 2'b01, pa, ra, any);
    xbit(1'b1, s, oe);
    xbit(1'b0, s, oe);
    for (int i = 15; i >= 0; i--) xbit(d[i], s, oe);
    mdio_drv = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic fwr(logic [15:0] d);
    @(negedge clk);
    fw_we = 1; fw_wd = d;
    @(negedge clk);
    fw_we = 0;
  endtask

  task automatic outs(string req, logic s, logic d, logic i);
    check({req, " outs"}, {28'd0, speed_o, dup_o, iso_o, men_o}, {28'd0, s, d, i, ~i});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state: isolated
    check("R1 reset iso", {30'd0, iso_o, men_o}, 32'b10);
    rst_n = 1;
    repeat (3) @(negedge clk);
    outs("R1 R9 strapA", 1, 1, 0);
    mrd(5'h08, 5'd0, 16'h2100, "R1 R2 ctrl strapA", 1);
    mrd(5'h08, 5'd1, 16'h7805, "R5 status", 1);
    mrd(5'h08, 5'd2, 16'h2A5C, "R10 id hi", 1);
    mrd(5'h08, 5'd3, 16'h9C31, "R10 id lo", 1);
    mrd(5'h08, 5'd7, 16'h0000, "R10 unmapped", 1);
    mrd(5'h00, 5'd0, 16'h0000, "R4 wrong addr read", 0);
    mwr(5'h10, 5'd0, 16'h0400);
    mrd(5'h08, 5'd0, 16'h2100, "R4 wrong addr write ignored", 1);
    outs("R4 outs kept", 1, 1, 0);
    mwr(5'h08, 5'd0, 16'h7EFF);
    outs("R6 R9 masked write", 1, 0, 1);
    mrd(5'h08, 5'd0, 16'h6400, "R6 masked readback", 1);
    mwr(5'h08, 5'd1, 16'h0000);
    mrd(5'h08, 5'd1, 16'h7805, "R5 status write ignored", 1);
    mwr(5'h08, 5'd0, 16'h8000);
    outs("R7 reload outs", 1, 1, 0);
    mrd(5'h08, 5'd0, 16'h2100, "R7 reload readback", 1);
    mwr(5'h08, 5'd0, 16'h0000, 16);
    mrd(5'h08, 5'd0, 16'h2100, "R3 short preamble write ignored", 1);
    mwr(5'h08, 5'd0, 16'h2100);
    mrd(5'h08, 5'd0, 16'h0000, "R3 short preamble read", 0, 16);
    fwr(16'h0100);
    outs("R8 R9 fw write", 0, 1, 0);
    mrd(5'h08, 5'd0, 16'h0100, "R8 fw readback", 1);
    fwr(16'h8400);
    outs("R7 R8 fw reload", 1, 1, 0);
    // strap set B
    rst_n = 0; spd = 0; dup = 0; iso = 1; adr = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    outs("R1 R9 strapB", 0, 0, 1);
    mrd(5'h18, 5'd0, 16'h0400, "R1 R2 ctrl strapB", 1);
    mrd(5'h08, 5'd0, 16'h0000, "R2 R4 old addr", 0);
    mrd(5'h18, 5'd1, 16'h7805, "R5 status strapB", 1);
    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule